// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands over several clock cycles and needs only one adder as wide as an operand. A one-cycle `start` pulse while the block is idle captures the multiplicand into a holding register. It also loads the double-width product register with zeros in its upper half and the multiplier in its lower half. The low half of the product register therefore doubles as the multiplier store, and no separate multiplier register is needed.

Each busy cycle runs one step. The block looks at the least significant bit of the product register. If that bit is set, the multiplicand is added to the upper half and the adder's carry-out is kept. The carry, upper half and lower half are then shifted right one place as one wide value. After exactly `WIDTH` steps, `busy` drops, `done` pulses for one cycle, and the full product stays on `product` until the next accepted start.

The step adder is selected by a parameter: a behavioural sum, a bit-serial ripple chain, or group lookahead where carries skip across fixed-size groups. All three give the same results.

Top module: `seqmul_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` sampled high while `busy` is 0 sets `busy` at that edge and loads `product` with `{WIDTH zeros, mplier}`.
- R3: When `done` is 1, `product` equals the unsigned product `mcand * mplier` of the operands captured at the accepted start, for every operand value including 0, 1 and all ones.
- R4: After an accepted start, `busy` stays high for exactly `WIDTH` cycles. `done` is 1 in the first cycle in which `busy` is low again.
- R5: `done` is never high in two consecutive cycles.
- R6: While idle and no start is accepted, `product` holds its value, even if `mcand` and `mplier` change.
- R7: A `start` sampled while `busy` is 1 is ignored. It changes neither the result nor the number of busy cycles.
- R8: A `start` sampled in the same cycle that `done` is high is accepted. The next run begins at once, with the product register reloaded from the new operands.
- R9: Each step forms the value (carry, upper half + (product bit 0 ? multiplicand : 0), lower half) and shifts it right by one. After the first step, `product` equals `({mplier[0] ? {1'b0,mcand} : 0, mplier}) >> 1`. A step that does not add leaves the top bit of `product` at 0.
- R10: The ripple and group-lookahead adder variants give the same product as an arithmetic multiply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a new multiply; taken only while idle |
| mcand | input | WIDTH | Multiplicand operand, captured on an accepted start |
| mplier | input | WIDTH | Multiplier operand, loaded into the low product half |
| busy | output | 1 | High while the steps are running |
| done | output | 1 | One-cycle pulse when the product is complete |
| product | output | 2*WIDTH | Product register; holds the result when idle |

## Verification
Two pairs of events can land on the same edge. One is the completion pulse and a fresh start: the bench raises `start` exactly in the cycle it sees `done`. It then requires `busy` high and the product register reloaded with the new multiplier one cycle later, and a correct second result. The other is a start that arrives during the run: the bench holds `start` high, with different operand values, over several busy cycles. It then requires the unchanged busy length and the original product. Products are compared against a wide arithmetic multiply in the bench, exhaustively for a 4-bit ripple instance and over corner and pseudo-random operands for the 32-bit lookahead instance.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;

   // Adder implementation used for the per-step accumulate
   typedef enum logic [1:0] {
      ADD_BEHAV     = 2'd0,
      ADD_RIPPLE    = 2'd1,
      ADD_LOOKAHEAD = 2'd2
   } add_kind_e;

   // Bits needed to count steps 0 .. n-1
   function automatic int step_cnt_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/seqmul_add.sv
module seqmul_add
   import seqmul_pkg::*;
#(
   parameter int        W    = 32,
   parameter add_kind_e KIND = ADD_LOOKAHEAD,
   parameter int        GRP  = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum,
   output logic         cout
);

   localparam int NGRP = (W + GRP - 1) / GRP;

   if (W < 1) begin : g_bad_width
      $error("seqmul_add: W must be at least 1");
   end
   if (KIND == ADD_LOOKAHEAD && (GRP < 1 || (W % GRP) != 0)) begin : g_bad_grp
      $error("seqmul_add: lookahead needs W to be a multiple of GRP");
   end

   if (KIND == ADD_BEHAV) begin : g_behav
      logic [W:0] full;
      assign full = {1'b0, a} + {1'b0, b};
      assign sum  = full[W-1:0];
      assign cout = full[W];
   end else if (KIND == ADD_RIPPLE) begin : g_ripple
      logic [W-1:0] s_bits;
      logic         c_last;
      always_comb begin : chain
         logic c;
         c = 1'b0;
         for (int i = 0; i < W; i++) begin
            s_bits[i] = a[i] ^ b[i] ^ c;
            c         = (a[i] & b[i]) | ((a[i] ^ b[i]) & c);
         end
         c_last = c;
      end
      assign sum  = s_bits;
      assign cout = c_last;
   end else begin : g_cla
      logic [W-1:0]    gen, prop;
      logic [NGRP-1:0] grp_g, grp_p, grp_ci;
      logic            carry_last;

      assign gen  = a & b;
      assign prop = a ^ b;

      for (genvar j = 0; j < NGRP; j++) begin : g_grp
         logic [GRP-1:0] gj, pj, sj;
         logic           gg, gp;

         assign gj = gen[j*GRP +: GRP];
         assign pj = prop[j*GRP +: GRP];

         // group generate / propagate
         always_comb begin
            gg = 1'b0;
            gp = 1'b1;
            for (int k = 0; k < GRP; k++) begin
               gg = gj[k] | (pj[k] & gg);
               gp = gp & pj[k];
            end
         end

         // sum bits of this group from its lookahead carry-in
         always_comb begin : grp_sum
            logic c;
            c = grp_ci[j];
            for (int k = 0; k < GRP; k++) begin
               sj[k] = pj[k] ^ c;
               c     = gj[k] | (pj[k] & c);
            end
         end

         assign grp_g[j]             = gg;
         assign grp_p[j]             = gp;
         assign sum[j*GRP +: GRP]    = sj;
      end

      // carries skip across whole groups
      always_comb begin : grp_chain
         logic c;
         c = 1'b0;
         for (int j = 0; j < NGRP; j++) begin
            grp_ci[j] = c;
            c         = grp_g[j] | (grp_p[j] & c);
         end
         carry_last = c;
      end

      assign cout = carry_last;
   end

endmodule

// File: rtl/seqmul_seq.sv
module seqmul_seq
   import seqmul_pkg::*;
#(
   parameter int W = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done,
   output logic load,
   output logic step
);

   localparam int            CW   = step_cnt_bits(W);
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   logic [CW-1:0] cnt;

   assign load = start & ~busy;
   assign step = busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         cnt  <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy <= 1'b1;
               cnt  <= '0;
            end
         end else begin
            if (cnt == LAST) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
            cnt <= cnt + 1'b1;
         end
      end
   end

   a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r4_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && (cnt != LAST)) |=> (busy && (cnt == $past(cnt) + 1'b1)));

   a_r8_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> (busy && (cnt == '0)));

endmodule

// File: rtl/seqmul_dp.sv
module seqmul_dp
   import seqmul_pkg::*;
#(
   parameter int        W    = 32,
   parameter add_kind_e KIND = ADD_LOOKAHEAD,
   parameter int        GRP  = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           step,
   input  logic [W-1:0]   mcand,
   input  logic [W-1:0]   mplier,
   output logic [2*W-1:0] prod
);

   localparam int PW = 2 * W;

   logic [W-1:0]  mcand_q;
   logic [PW-1:0] prod_q;
   logic [W-1:0]  addend;
   logic [W-1:0]  add_sum;
   logic          add_co;

   assign addend = prod_q[0] ? mcand_q : '0;

   seqmul_add #(
      .W   (W),
      .KIND(KIND),
      .GRP (GRP)
   ) u_add (
      .a   (prod_q[PW-1:W]),
      .b   (addend),
      .sum (add_sum),
      .cout(add_co)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mcand_q <= '0;
         prod_q  <= '0;
      end else if (load) begin
         mcand_q <= mcand;
         prod_q  <= {{W{1'b0}}, mplier};
      end else if (step) begin
         prod_q  <= {add_co, add_sum, prod_q[W-1:1]};
      end
   end

   assign prod = prod_q;

   a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> $stable(prod_q));

   a_r2_upper_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (prod_q[PW-1:W] == '0));

   a_r9_no_add_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !prod_q[0]) |=> !prod_q[PW-1]);

   a_r7_mcand_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(mcand_q));

endmodule

// File: rtl/seqmul_top.sv
module seqmul_top
   import seqmul_pkg::*;
#(
   parameter int        WIDTH    = 32,
   parameter add_kind_e ADD_KIND = ADD_LOOKAHEAD,
   parameter int        GRP      = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [WIDTH-1:0]   mcand,
   input  logic [WIDTH-1:0]   mplier,
   output logic               busy,
   output logic               done,
   output logic [2*WIDTH-1:0] product
);

   localparam int RW = $clog2(WIDTH + 1) + 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("seqmul_top: WIDTH must be at least 2");
   end

   logic load, step;

   seqmul_seq #(
      .W(WIDTH)
   ) u_seq (
      .clk  (clk),
      .rst_n(rst_n),
      .start(start),
      .busy (busy),
      .done (done),
      .load (load),
      .step (step)
   );

   seqmul_dp #(
      .W   (WIDTH),
      .KIND(ADD_KIND),
      .GRP (GRP)
   ) u_dp (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .step  (step),
      .mcand (mcand),
      .mplier(mplier),
      .prod  (product)
   );

   // run-length observer for the step-count property
   logic [RW-1:0] run_len;

   always_ff @(posedge clk) begin
      if (!rst_n)      run_len <= '0;
      else if (load)   run_len <= '0;
      else if (busy)   run_len <= run_len + 1'b1;
   end

   a_r4_busy_span: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_len == RW'(WIDTH)));

   a_r2_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

endmodule

// File: tb/tb_seqmul_top.sv
module tb_seqmul_top;
   import seqmul_pkg::*;

   localparam int W  = 32;
   localparam int NW = 4;

   logic clk = 1'b0;
   always #4 clk = ~clk;   // 8 ns period

   logic rst_n;

   logic           st;
   logic [W-1:0]   a, b;
   logic           busy, done;
   logic [2*W-1:0] prod;

   logic            n_st;
   logic [NW-1:0]   na, nb;
   logic            n_busy, n_done;
   logic [2*NW-1:0] n_prod;

   int checks = 0;
   int fails  = 0;
   logic [31:0] rng = 32'h1234_5678;

   seqmul_top #(.WIDTH(W), .ADD_KIND(ADD_LOOKAHEAD), .GRP(4)) dut (
      .clk(clk), .rst_n(rst_n), .start(st), .mcand(a), .mplier(b),
      .busy(busy), .done(done), .product(prod));

   seqmul_top #(.WIDTH(NW), .ADD_KIND(ADD_RIPPLE), .GRP(4)) dut_nar (
      .clk(clk), .rst_n(rst_n), .start(n_st), .mcand(na), .mplier(nb),
      .busy(n_busy), .done(n_done), .product(n_prod));

   task automatic chk(input bit ok, input string req,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   function automatic logic [31:0] next_rng(input logic [31:0] s);
      logic [31:0] x;
      x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   // count busy cycles until idle, holding start for cycles [lo,hi) of the run
   task automatic wait_idle(input int first, input int lo, input int hi, output int n);
      n = first;
      while (busy && n < 200) begin
         n++;
         st = (n >= lo && n < hi);
         if (st) begin a = ~a; b = b + 32'h1357; end
         @(negedge clk);
      end
      st = 1'b0;
   endtask

   task automatic run32(input logic [W-1:0] x, input logic [W-1:0] y, input bit poke);
      logic [63:0] exp;
      logic [64:0] s1;
      int n;
      exp = {32'b0, x} * {32'b0, y};
      s1  = {(y[0] ? {1'b0, x} : 33'b0), y} >> 1;
      @(negedge clk);
      a = x; b = y; st = 1'b1;
      @(negedge clk);
      st = 1'b0;
      chk(busy && prod == {32'b0, y}, "R2", prod, {32'b0, y});
      @(negedge clk);
      chk(prod == s1[63:0], "R9", prod, s1[63:0]);
      if (poke) wait_idle(1, 3, 7, n);   // R7: start held while busy
      else      wait_idle(1, 0, 0, n);
      chk(n == W, poke ? "R7" : "R4", 64'(n), 64'(W));
      chk(done && !busy, "R4", {62'b0, done, busy}, 64'h2);
      chk(prod == exp, poke ? "R7" : "R3", prod, exp);
      a = ~x; b = ~y;                      // idle operand change, no start
      @(negedge clk);
      chk(!done, "R5", {63'b0, done}, 64'h0);
      chk(prod == exp, "R6", prod, exp);
   endtask

   task automatic run4(input logic [NW-1:0] x, input logic [NW-1:0] y);
      logic [7:0] exp;
      int n;
      exp = {4'b0, x} * {4'b0, y};
      @(negedge clk);
      na = x; nb = y; n_st = 1'b1;
      @(negedge clk);
      n_st = 1'b0;
      n = 0;
      while (n_busy && n < 50) begin n++; @(negedge clk); end
      chk(n == NW && n_done && n_prod == exp, "R10",
          {48'b0, n_prod, 8'(n)}, {48'b0, exp, 8'(NW)});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin : main
      logic [W-1:0] x2, y2;
      int n;
      rst_n = 1'b0; st = 1'b0; a = '0; b = '0;
      n_st = 1'b0; na = '0; nb = '0;
      repeat (3) @(negedge clk);
      chk(!busy && !done && prod == '0, "R1", prod, 64'h0);
      chk(!n_busy && !n_done && n_prod == '0, "R1", {56'b0, n_prod}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && prod == '0, "R1", prod, 64'h0);

      // R3 corner operands
      run32(32'h0, 32'h0, 1'b0);
      run32(32'h0, 32'hFFFF_FFFF, 1'b0);
      run32(32'hFFFF_FFFF, 32'h0, 1'b0);
      run32(32'h1, 32'hDEAD_BEEF, 1'b0);
      run32(32'hCAFE_F00D, 32'h1, 1'b0);
      run32(32'h1, 32'h1, 1'b0);
      run32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
      run32(32'hFFFF_FFFF, 32'h1, 1'b0);
      run32(32'hAAAA_AAAA, 32'h5555_5555, 1'b0);
      run32(32'h8000_0000, 32'h8000_0000, 1'b0);
      for (int i = 0; i < 30; i++) begin
         rng = next_rng(rng); x2 = rng;
         rng = next_rng(rng); y2 = rng;
         run32(x2, y2, 1'b0);
      end

      // R7 start while busy
      run32(32'h1234_5678, 32'h9ABC_DEF1, 1'b1);
      run32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);

      // R8 start in the done cycle
      @(negedge clk);
      a = 32'h0F0F_0F0F; b = 32'h7777_7777; st = 1'b1;
      @(negedge clk);
      st = 1'b0;
      wait_idle(0, 0, 0, n);
      x2 = 32'hFFFF_FFFE; y2 = 32'hFFFF_FFFD;
      a = x2; b = y2; st = 1'b1;          // done is high in this cycle
      @(negedge clk);
      st = 1'b0;
      chk(busy && prod == {32'b0, y2}, "R8", prod, {32'b0, y2});
      wait_idle(0, 0, 0, n);
      chk(done && prod == {32'b0, x2} * {32'b0, y2}, "R8", prod,
          {32'b0, x2} * {32'b0, y2});

      // R10 exhaustive on the narrow ripple instance
      for (int i = 0; i < 16; i++)
         for (int j = 0; j < 16; j++)
            run4(NW'(i), NW'(j));

      finish_run();
   end

endmodule